// File: doc/BRIEF.md
# Transparent Translation Range Matcher

This block decides in a single combinational step whether a logical address lies inside one of the windows that bypass page-table translation. It holds four 32-bit window registers. Two serve data accesses and two serve instruction fetches. Each register describes a window by the top byte of the address, with a per-bit don't-care mask. A register can also be limited to one privilege level and can forbid writes.

Every cycle, the access side presents an address, a supervisor flag and a data/instruction flag. The block returns a 2-bit verdict: miss, hit with access allowed, or hit with writes forbidden. It also returns the cache-mode and user-attribute fields of the register that produced the hit. These fields are carried through as stored and are not interpreted. A small write port loads any of the four registers.

Top module: `xlate_window_match`

## Requirements
- R1: After reset all four registers read as zero, so every access returns a miss (2'b00) with zero cache and user fields.
- R2: Register bits 31:24 hold a base byte that is compared with address bits 31:24. A 1 in register bits 23:16 makes the corresponding address bit a don't-care.
- R3: A register whose enable bit (bit 15) is 0 never produces a hit.
- R4: When the privilege-ignore bit (bit 14) is 0, a register hits only if its supervisor bit (bit 13) equals the access supervisor flag. When bit 14 is 1, the privilege level is not considered.
- R5: A hitting register with its write-protect bit (bit 2) set yields 2'b10. Otherwise a hit yields 2'b01. The value 2'b11 never appears.
- R6: Within the selected pair, register 0 decides whenever it hits, even if register 1 also hits. Register 1 decides only when register 0 misses.
- R7: When the data flag is 1, the data pair (write selects 0 and 1) is used. When it is 0, the instruction pair (write selects 2 and 3) is used. The unselected pair has no effect.
- R8: The verdict and attribute outputs follow the access inputs within the same cycle, with no clock edge in between.
- R9: On a hit, the cache-mode field (register bits 7:6) and the user field (register bits 10:9) of the deciding register appear on the outputs. On a miss, both outputs are zero.
- R10: A write presented with the write enable high takes effect at the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0/1 data pair, 2/3 instruction pair |
| cfg_wdata | input | 32 | Register write value |
| acc_addr | input | 32 | Logical address of the access |
| acc_super | input | 1 | 1 for a supervisor-mode access |
| acc_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| hit_result | output | 2 | 00 miss, 01 hit with access allowed, 10 hit with writes forbidden |
| hit_cache | output | 2 | Cache-mode field of the deciding register |
| hit_user | output | 2 | User-attribute field of the deciding register |

## Verification
The clocked assertions sample the access inputs and the verdict only at rising edges. They therefore assume the inputs are stable and known around each edge. The bench changes access inputs and write-port inputs only just after a falling edge. It then probes the verdict one time unit later, well before the next rising edge.

Register writes are the only state. The bench reaches every register solely through the write port, so the write-landing check always sees a legal select value.

// File: rtl/ttm_pkg.sv
package ttm_pkg;

    localparam int ADDR_W   = 32;
    localparam int CMP_W    = 8;
    localparam int NUM_PAIR = 2;
    localparam int PAIR_SZ  = 2;
    localparam int NUM_REG  = NUM_PAIR * PAIR_SZ;
    localparam int SEL_W    = $clog2(NUM_REG);

    // Window register layout, bit 31 first.
    typedef struct packed {
        logic [CMP_W-1:0] base;      // 31:24
        logic [CMP_W-1:0] mask;      // 23:16
        logic             en;        // 15
        logic             ign_priv;  // 14
        logic             sup;       // 13
        logic [1:0]       rsv_a;     // 12:11
        logic [1:0]       user;      // 10:9
        logic             rsv_b;     // 8
        logic [1:0]       cache;     // 7:6
        logic [2:0]       rsv_c;     // 5:3
        logic             wp;        // 2
        logic [1:0]       rsv_d;     // 1:0
    } win_reg_t;

    typedef enum logic [1:0] {
        RES_MISS  = 2'b00,
        RES_OK    = 2'b01,
        RES_NO_WR = 2'b10
    } win_res_e;

    typedef struct packed {
        win_res_e   res;
        logic [1:0] cache;
        logic [1:0] user;
    } win_out_t;

    // Register file next-state bundle
    typedef struct packed {
        win_reg_t [NUM_REG-1:0] regs;
    } rf_state_t;

endpackage

// File: rtl/ttm_regfile.sv
module ttm_regfile
    import ttm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [SEL_W-1:0]       cfg_sel,
    input  logic [31:0]            cfg_wdata,
    output win_reg_t [NUM_REG-1:0] regs_o
);

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REG; i++) begin
            if (cfg_we && (cfg_sel == SEL_W'(i))) begin
                st_d.regs[i] = win_reg_t'(cfg_wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;

    // R10: a write is visible in the selected slot after the next edge
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (st_q.regs[$past(cfg_sel)] == win_reg_t'($past(cfg_wdata))));

    // R1: first edge after reset release sees cleared registers
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q == '0));

endmodule

// File: rtl/ttm_window.sv
module ttm_window
    import ttm_pkg::*;
(
    input  win_reg_t         cfg,
    input  logic [CMP_W-1:0] addr_hi,
    input  logic             acc_super,
    output logic             hit,
    output logic             no_write
);

    logic [CMP_W-1:0] diff_d;
    logic             addr_ok_d;
    logic             priv_ok_d;

    always_comb begin
        diff_d    = (addr_hi ^ cfg.base) & ~cfg.mask;
        addr_ok_d = (diff_d == '0);
        priv_ok_d = cfg.ign_priv || (cfg.sup == acc_super);
        hit       = cfg.en && addr_ok_d && priv_ok_d;
        no_write  = hit && cfg.wp;
    end

endmodule

// File: rtl/ttm_pair.sv
module ttm_pair
    import ttm_pkg::*;
(
    input  win_reg_t [PAIR_SZ-1:0] cfg,
    input  logic [CMP_W-1:0]       addr_hi,
    input  logic                   acc_super,
    output win_out_t               out_o,
    output logic [PAIR_SZ-1:0]     hit_o
);

    logic [PAIR_SZ-1:0] nw;

    for (genvar g = 0; g < PAIR_SZ; g++) begin : g_win
        ttm_window u_win (
            .cfg       (cfg[g]),
            .addr_hi   (addr_hi),
            .acc_super (acc_super),
            .hit       (hit_o[g]),
            .no_write  (nw[g])
        );
    end

    // Lowest index wins: scan from highest down so index 0 overrides.
    always_comb begin
        out_o = '{res: RES_MISS, cache: 2'b00, user: 2'b00};
        for (int i = PAIR_SZ - 1; i >= 0; i--) begin
            if (hit_o[i]) begin
                out_o.res   = nw[i] ? RES_NO_WR : RES_OK;
                out_o.cache = cfg[i].cache;
                out_o.user  = cfg[i].user;
            end
        end
    end

endmodule

// File: rtl/xlate_window_match.sv
module xlate_window_match
    import ttm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic              acc_data,
    output logic [1:0]        hit_result,
    output logic [1:0]        hit_cache,
    output logic [1:0]        hit_user
);

    localparam int PAIR_DATA = 0;
    localparam int PAIR_INST = 1;

    win_reg_t [NUM_REG-1:0]  regs;
    win_out_t [NUM_PAIR-1:0] pair_out;
    logic     [PAIR_SZ-1:0]  pair_hit [NUM_PAIR];
    logic     [CMP_W-1:0]    addr_hi;
    win_out_t                sel_d;

    assign addr_hi = acc_addr[ADDR_W-1 -: CMP_W];

    ttm_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .regs_o    (regs)
    );

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        ttm_pair u_pair (
            .cfg       (regs[p*PAIR_SZ +: PAIR_SZ]),
            .addr_hi   (addr_hi),
            .acc_super (acc_super),
            .out_o     (pair_out[p]),
            .hit_o     (pair_hit[p])
        );
    end

    always_comb begin
        sel_d = acc_data ? pair_out[PAIR_DATA] : pair_out[PAIR_INST];
    end

    assign hit_result = sel_d.res;
    assign hit_cache  = sel_d.cache;
    assign hit_user   = sel_d.user;

    // R5: the unused code never appears
    a_r5_result_legal: assert property (@(posedge clk) disable iff (!rst_n)
        hit_result != 2'b11);

    // R6: register 0 decides when it hits
    a_r6_reg0_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_data && pair_hit[PAIR_DATA][0]) |->
            (hit_result == (regs[0].wp ? 2'b10 : 2'b01)));

    // R3: with both selected registers disabled the verdict is a miss
    a_r3_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_data && !regs[2].en && !regs[3].en) |-> (hit_result == 2'b00));

    // R9: attributes are quiet on a miss
    a_r9_attr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_result == 2'b00) |-> (hit_cache == 2'b00 && hit_user == 2'b00));

    // R4: privilege mismatch on the only enabled data register gives a miss
    a_r4_priv_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_data && !regs[1].en && !regs[0].ign_priv && (regs[0].sup != acc_super))
            |-> (hit_result == 2'b00));

endmodule

// File: tb/tb_xlate_window_match.sv
module tb_xlate_window_match;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic        acc_data = 1'b1;
    logic [1:0]  hit_result, hit_cache, hit_user;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_window_match dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_super(acc_super),
        .acc_data(acc_data), .hit_result(hit_result), .hit_cache(hit_cache),
        .hit_user(hit_user)
    );

    function automatic logic [31:0] mk(input logic [7:0] base, input logic [7:0] mask,
                                       input logic en, input logic ign, input logic sup,
                                       input logic wp, input logic [1:0] cm,
                                       input logic [1:0] ua);
        return {base, mask, en, ign, sup, 2'b00, ua, 1'b0, cm, 3'b000, wp, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) wr(2'(i), 32'h0);
    endtask

    task automatic probe(input logic [31:0] a, input logic s, input logic d);
        @(negedge clk);
        acc_addr = a; acc_super = s; acc_data = d;
        #1;
    endtask

    task automatic t_reset();
        for (int d = 0; d < 2; d++) begin
            probe(32'h0000_0000, 1'b0, 1'(d)); chk("R1 zero addr", hit_result, 2'b00);
            probe(32'hFFFF_FFFF, 1'b1, 1'(d)); chk("R1 ones addr", hit_result, 2'b00);
            chk("R1 cache", hit_cache, 2'b00);
            chk("R1 user", hit_user, 2'b00);
        end
    endtask

    task automatic t_base_mask();
        clear_all();
        wr(2'd0, mk(8'h40, 8'h0F, 1, 1, 0, 0, 0, 0));
        probe(32'h4512_3456, 0, 1); chk("R2 masked low nibble", hit_result, 2'b01);
        probe(32'h4F00_0000, 0, 1); chk("R2 all mask bits", hit_result, 2'b01);
        probe(32'h5012_3456, 0, 1); chk("R2 unmasked differs", hit_result, 2'b00);
        wr(2'd0, mk(8'h40, 8'h00, 1, 1, 0, 0, 0, 0));
        probe(32'h40FF_FFFF, 0, 1); chk("R2 exact match", hit_result, 2'b01);
        probe(32'h4100_0000, 0, 1); chk("R2 exact miss", hit_result, 2'b00);
    endtask

    task automatic t_enable();
        clear_all();
        wr(2'd0, mk(8'h40, 8'hFF, 0, 1, 0, 0, 0, 0));
        probe(32'h4000_0000, 0, 1); chk("R3 disabled", hit_result, 2'b00);
        probe(32'h4000_0000, 1, 1); chk("R3 disabled super", hit_result, 2'b00);
    endtask

    task automatic t_priv();
        clear_all();
        wr(2'd0, mk(8'h10, 8'h00, 1, 0, 1, 0, 0, 0));
        probe(32'h1000_0000, 1, 1); chk("R4 super reg super acc", hit_result, 2'b01);
        probe(32'h1000_0000, 0, 1); chk("R4 super reg user acc", hit_result, 2'b00);
        wr(2'd0, mk(8'h10, 8'h00, 1, 0, 0, 0, 0, 0));
        probe(32'h1000_0000, 0, 1); chk("R4 user reg user acc", hit_result, 2'b01);
        probe(32'h1000_0000, 1, 1); chk("R4 user reg super acc", hit_result, 2'b00);
        wr(2'd0, mk(8'h10, 8'h00, 1, 1, 0, 0, 0, 0));
        probe(32'h1000_0000, 1, 1); chk("R4 ignore super", hit_result, 2'b01);
        probe(32'h1000_0000, 0, 1); chk("R4 ignore user", hit_result, 2'b01);
    endtask

    task automatic t_wp();
        clear_all();
        wr(2'd1, mk(8'h30, 8'h00, 1, 1, 0, 1, 0, 0));
        probe(32'h3000_1000, 0, 1); chk("R5 write protected", hit_result, 2'b10);
        wr(2'd1, mk(8'h30, 8'h00, 1, 1, 0, 0, 0, 0));
        probe(32'h3000_1000, 0, 1); chk("R5 writable", hit_result, 2'b01);
    endtask

    task automatic t_priority();
        clear_all();
        wr(2'd0, mk(8'h40, 8'h00, 1, 1, 0, 1, 2'd1, 2'd1));
        wr(2'd1, mk(8'h40, 8'hFF, 1, 1, 0, 0, 2'd2, 2'd3));
        probe(32'h4000_0000, 0, 1); chk("R6 reg0 wins", hit_result, 2'b10);
        chk("R9 reg0 cache", hit_cache, 2'd1);
        chk("R9 reg0 user", hit_user, 2'd1);
        probe(32'h8000_0000, 0, 1); chk("R6 reg1 fallback", hit_result, 2'b01);
        chk("R9 reg1 cache", hit_cache, 2'd2);
        chk("R9 reg1 user", hit_user, 2'd3);
        wr(2'd0, 32'h0);
        probe(32'h4000_0000, 0, 1); chk("R6 reg0 off", hit_result, 2'b01);
    endtask

    task automatic t_pair();
        clear_all();
        wr(2'd2, mk(8'h20, 8'h00, 1, 1, 0, 0, 2'd3, 2'd2));
        probe(32'h2000_0000, 0, 0); chk("R7 inst pair used", hit_result, 2'b01);
        chk("R9 inst cache", hit_cache, 2'd3);
        probe(32'h2000_0000, 0, 1); chk("R7 data pair ignores inst", hit_result, 2'b00);
        chk("R9 miss cache", hit_cache, 2'd0);
        chk("R9 miss user", hit_user, 2'd0);
        wr(2'd1, mk(8'h20, 8'h00, 1, 1, 0, 1, 0, 0));
        probe(32'h2000_0000, 0, 1); chk("R7 data pair", hit_result, 2'b10);
        probe(32'h2000_0000, 0, 0); chk("R7 inst unaffected", hit_result, 2'b01);
    endtask

    task automatic t_timing();
        clear_all();
        wr(2'd0, mk(8'h55, 8'h00, 1, 1, 0, 0, 0, 0));
        @(negedge clk);
        acc_addr = 32'h5500_0000; acc_data = 1; #1;
        chk("R8 same cycle hit", hit_result, 2'b01);
        acc_addr = 32'h5600_0000; #1;
        chk("R8 same cycle miss", hit_result, 2'b00);
        @(negedge clk);
        acc_addr = 32'h5600_0000;
        cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = mk(8'h56, 8'h00, 1, 1, 0, 1, 0, 0);
        #1;
        chk("R10 before edge", hit_result, 2'b00);
        @(negedge clk);
        cfg_we = 0; #1;
        chk("R10 after edge", hit_result, 2'b10);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base_mask();
        t_enable();
        t_priv();
        t_wp();
        t_priority();
        t_pair();
        t_timing();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule